// File: doc/BRIEF.md
# Microsequencer Next-Address Modifier

This block forms the address of the next microinstruction. A conditional branch or a dispatch does not act on the instruction that requests it. It leaves a modifier in a register, and that modifier is ORed into the NEXT field of the instruction that executes after it. Once that instruction has used it, the modifier is cleared. The branch function field selects one of five sources:
- a bus-zero test
- a shifter-negative test
- a shifter-zero test
- a dispatch on the low bus bits
- the ALU carry that was saved at the last load of L

The sequencer drives the branch function, the bus value, the shifter output, the NEXT field, the L-load strobe and the ALU carry of the instruction now executing. It receives the next microprogram address. The caller supplies the shifter output already formed from the L value at the start of the instruction and the current shift function. A memory stall suspends the cycle, and the stored modifier and the saved carry both keep their values.

Top module: `useq_next_addr`

## Requirements
- R1: `next_mpc_o` equals `next_i` ORed with the modifier stored by the last accepted instruction. An accepted instruction with branch code 0, 6 or 7 stores a zero modifier, so a modifier is used once and is then cleared.
- R2: Branch code 1 (bus zero) stores modifier 1 when `bus_i` is zero, and 0 otherwise.
- R3: Branch code 2 (shifter negative) stores modifier 1 when bit 15 of `shift_i` is set, and 0 otherwise.
- R4: Branch code 3 (shifter zero) stores modifier 1 when `shift_i` is zero, and 0 otherwise.
- R5: Branch code 4 (dispatch) stores the low 10 bits of `bus_i` as the modifier.
- R6: Branch code 5 (carry) stores, in bit 0, the carry saved before the current instruction. The carry of the current instruction is not used, even when that instruction loads L.
- R7: An accepted instruction with `load_l_i` high saves `alu_carry_i` as the new saved carry. Without `load_l_i`, the saved carry keeps its value.
- R8: While `stall_i` is high, neither the modifier nor the saved carry changes.
- R9: Reset clears the modifier and the saved carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stall_i | input | 1 | Memory stall: the current cycle is suspended |
| func_i | input | 3 | Branch function code of the current instruction |
| bus_i | input | 16 | Bus value of the current instruction |
| shift_i | input | 16 | Shifter output of the current instruction |
| next_i | input | 10 | NEXT field of the current instruction |
| load_l_i | input | 1 | Current instruction loads L |
| alu_carry_i | input | 1 | ALU carry of the current instruction |
| next_mpc_o | output | 10 | Next microprogram address |

## Verification
The assertions treat every cycle with `stall_i` low as an executed instruction whose inputs are valid. They treat a stalled cycle as one whose inputs carry no meaning. The stimulus therefore changes every input at will during stalls, and this shows that a stall leaves the stored state alone. Inputs change only away from the rising edge. The random bus and shifter values are weighted toward zero and toward the sign boundary, so that both outcomes of each test occur often. Directed cases cover a carry branch in the same instruction as an L load, a full-width dispatch and a branch that follows reset.

// File: rtl/useq_pkg.sv
package useq_pkg;
  typedef enum logic [2:0] {
    BR_NONE     = 3'd0,
    BR_BUS_ZERO = 3'd1,
    BR_SH_NEG   = 3'd2,
    BR_SH_ZERO  = 3'd3,
    BR_BUS_DISP = 3'd4,
    BR_CARRY    = 3'd5
  } br_fn_e;
endpackage

// File: rtl/useq_cond_eval.sv
module useq_cond_eval
  import useq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10
) (
  input  logic [2:0]        func_i,
  input  logic [DATA_W-1:0] bus_i,
  input  logic [DATA_W-1:0] shift_i,
  input  logic              carry_q_i,
  output logic [ADDR_W-1:0] mod_d_o
);
  logic [ADDR_W-1:0] disp_val;

  generate
    if (DATA_W >= ADDR_W) begin : g_slice
      assign disp_val = bus_i[ADDR_W-1:0];
    end else begin : g_ext
      assign disp_val = {{(ADDR_W-DATA_W){1'b0}}, bus_i};
    end
  endgenerate

  always_comb begin
    mod_d_o = '0;
    unique case (func_i)
      BR_BUS_ZERO: mod_d_o[0] = (bus_i == '0);
      BR_SH_NEG:   mod_d_o[0] = shift_i[DATA_W-1];
      BR_SH_ZERO:  mod_d_o[0] = (shift_i == '0);
      BR_BUS_DISP: mod_d_o    = disp_val;
      BR_CARRY:    mod_d_o[0] = carry_q_i;  // carry saved before this instruction
      default:     mod_d_o    = '0;
    endcase
  end
endmodule

// File: rtl/useq_carry_hold.sv
module useq_carry_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  input  logic load_l_i,
  input  logic alu_carry_i,
  output logic carry_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  carry_q_o <= 1'b0;
    else if (adv_i && load_l_i)   carry_q_o <= alu_carry_i;
  end
endmodule

// File: rtl/useq_mod_reg.sv
module useq_mod_reg #(
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic [ADDR_W-1:0] mod_d_i,
  output logic [ADDR_W-1:0] mod_q_o
);
  // Each accepted instruction replaces the modifier, so a used modifier is cleared.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mod_q_o <= '0;
    else if (adv_i) mod_q_o <= mod_d_i;
  end
endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stall_i,
  input  logic [2:0]        func_i,
  input  logic [DATA_W-1:0] bus_i,
  input  logic [DATA_W-1:0] shift_i,
  input  logic [ADDR_W-1:0] next_i,
  input  logic              load_l_i,
  input  logic              alu_carry_i,
  output logic [ADDR_W-1:0] next_mpc_o
);
  logic              adv;
  logic              carry_q;
  logic [ADDR_W-1:0] mod_d;
  logic [ADDR_W-1:0] mod_q;

  assign adv = !stall_i;

  useq_cond_eval #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_eval (
    .func_i    (func_i),
    .bus_i     (bus_i),
    .shift_i   (shift_i),
    .carry_q_i (carry_q),
    .mod_d_o   (mod_d)
  );

  useq_carry_hold u_carry (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .adv_i       (adv),
    .load_l_i    (load_l_i),
    .alu_carry_i (alu_carry_i),
    .carry_q_o   (carry_q)
  );

  useq_mod_reg #(.ADDR_W(ADDR_W)) u_mod (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .adv_i   (adv),
    .mod_d_i (mod_d),
    .mod_q_o (mod_q)
  );

  assign next_mpc_o = next_i | mod_q;
endmodule

// File: rtl/useq_next_addr_chk.sv
module useq_next_addr_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              stall_i,
  input logic [2:0]        func_i,
  input logic [DATA_W-1:0] bus_i,
  input logic [DATA_W-1:0] shift_i,
  input logic              load_l_i,
  input logic              alu_carry_i,
  input logic [ADDR_W-1:0] mod_q,
  input logic              carry_q
);
  a_r1_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && (func_i == 3'd0 || func_i > 3'd5)) |=> (mod_q == '0));

  a_r2_bus_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && func_i == 3'd1) |=> (mod_q == ADDR_W'($past(bus_i) == '0)));

  a_r3_sh_neg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && func_i == 3'd2) |=> (mod_q == ADDR_W'($past(shift_i[DATA_W-1]))));

  a_r4_sh_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && func_i == 3'd3) |=> (mod_q == ADDR_W'($past(shift_i) == '0)));

  a_r5_dispatch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && func_i == 3'd4) |=> (mod_q == ADDR_W'($past(bus_i))));

  a_r6_old_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && func_i == 3'd5) |=> (mod_q == ADDR_W'($past(carry_q))));

  a_r7_carry_save: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && load_l_i) |=> (carry_q == $past(alu_carry_i)));

  a_r7_carry_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_l_i) |=> $stable(carry_q));

  a_r8_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> ($stable(mod_q) && $stable(carry_q)));

  always_comb begin
    if (!rst_ni) a_r9_reset: assert (mod_q == '0 && carry_q == 1'b0);
  end
endmodule

bind useq_next_addr useq_next_addr_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .stall_i     (stall_i),
  .func_i      (func_i),
  .bus_i       (bus_i),
  .shift_i     (shift_i),
  .load_l_i    (load_l_i),
  .alu_carry_i (alu_carry_i),
  .mod_q       (mod_q),
  .carry_q     (carry_q)
);

// File: tb/sim_useq_next_addr.sv
`timescale 1ns/1ps
module sim_useq_next_addr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stall;
  logic [2:0]  func;
  logic [15:0] bus, shv;
  logic [9:0]  nxt;
  logic        ld, cy;
  logic [9:0]  mpc;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [9:0] mod_m;
  logic       carry_m;
  string      tag;

  always #2.5 clk = ~clk;

  useq_next_addr u0 (
    .clk_i(clk), .rst_ni(rst_n), .stall_i(stall), .func_i(func),
    .bus_i(bus), .shift_i(shv), .next_i(nxt), .load_l_i(ld),
    .alu_carry_i(cy), .next_mpc_o(mpc)
  );

  function automatic logic [9:0] exp_mod(input logic [2:0] f, input logic [15:0] b,
                                         input logic [15:0] s, input logic c);
    case (f)
      3'd1: return {9'd0, b == 16'd0};
      3'd2: return {9'd0, s[15]};
      3'd3: return {9'd0, s == 16'd0};
      3'd4: return b[9:0];
      3'd5: return {9'd0, c};
      default: return 10'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic s, input logic [2:0] f);
    if (s) return "R8";
    case (f)
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6 R7";
      default: return "R1";
    endcase
  endfunction

  task automatic check(input logic [9:0] act, input logic [9:0] exp, input string t);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: next_mpc=%h expected=%h at %0t", t, act, exp, $time);
    end
  endtask

  // Drive one instruction, check the address it forms, then advance the model.
  task automatic step(input logic s, input logic [2:0] f, input logic [15:0] b,
                      input logic [15:0] sh, input logic [9:0] nx,
                      input logic l, input logic c);
    @(negedge clk);
    stall = s; func = f; bus = b; shv = sh; nxt = nx; ld = l; cy = c;
    #1;
    check(mpc, nx | mod_m, tag);
    @(posedge clk);
    if (!s) begin
      mod_m = exp_mod(f, b, sh, carry_m);
      if (l) carry_m = c;
    end
    tag = tag_of(s, f);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    stall = 0; func = 0; bus = 0; shv = 0; nxt = 0; ld = 0; cy = 0;
    mod_m = 0; carry_m = 0; tag = "R9";
    repeat (3) @(posedge clk);
    #1;
    check(mpc, 10'h000, "R9");
    @(negedge clk); rst_n = 1'b1;
    // R9: modifier clear after reset; carry branch reads a cleared carry
    step(0, 3'd5, 16'h1234, 16'h0, 10'h155, 0, 1);
    step(0, 3'd0, 16'h0, 16'h0, 10'h2aa, 0, 0);
    tag = "R9";
    step(0, 3'd0, 16'h0, 16'h0, 10'h100, 0, 0);
    // R2 both outcomes
    step(0, 3'd1, 16'h0000, 16'h0, 10'h010, 0, 0);
    step(0, 3'd1, 16'h0001, 16'h0, 10'h020, 0, 0);
    step(0, 3'd0, 16'h0, 16'h0, 10'h040, 0, 0);
    // R3 at the sign boundary
    step(0, 3'd2, 16'h0, 16'h8000, 10'h000, 0, 0);
    step(0, 3'd2, 16'h0, 16'h7fff, 10'h002, 0, 0);
    step(0, 3'd0, 16'h0, 16'h0, 10'h004, 0, 0);
    // R4
    step(0, 3'd3, 16'hffff, 16'h0000, 10'h000, 0, 0);
    step(0, 3'd3, 16'h0, 16'h0100, 10'h000, 0, 0);
    // R5 full-width dispatch, then R1 clear
    step(0, 3'd4, 16'hffff, 16'h0, 10'h000, 0, 0);
    step(0, 3'd0, 16'h0, 16'h0, 10'h000, 0, 0);
    step(0, 3'd7, 16'hffff, 16'h0, 10'h001, 0, 0);
    // R6/R7: a carry branch with an L load uses the old carry; the next sees the new one
    step(0, 3'd5, 16'h0, 16'h0, 10'h000, 1, 1);
    step(0, 3'd5, 16'h0, 16'h0, 10'h000, 0, 0);
    step(0, 3'd5, 16'h0, 16'h0, 10'h000, 1, 0);
    step(0, 3'd0, 16'h0, 16'h0, 10'h000, 0, 0);
    // R8: a stall holds a dispatch modifier and the carry
    step(0, 3'd4, 16'h03c5, 16'h0, 10'h000, 1, 1);
    step(1, 3'd4, 16'h0011, 16'h0, 10'h000, 1, 0);
    step(1, 3'd1, 16'h0000, 16'h0, 10'h200, 1, 0);
    step(0, 3'd5, 16'h0, 16'h0, 10'h000, 0, 0);
    step(0, 3'd0, 16'h0, 16'h0, 10'h000, 0, 0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] b, sh;
      b  = ($urandom_range(0, 3) == 0) ? 16'h0 : 16'($urandom);
      case ($urandom_range(0, 3))
        0: sh = 16'h0;
        1: sh = 16'h8000;
        2: sh = 16'h7fff;
        default: sh = 16'($urandom);
      endcase
      step($urandom_range(0, 7) == 0, 3'($urandom), b, sh, 10'($urandom),
           1'($urandom), 1'($urandom));
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial void'($urandom(32'd24681));
endmodule